// File: doc/BRIEF.md
# Audio Serial Bit and Frame Clock Divider

This block runs on an audio master clock and produces two derived clocks for a serial audio link. The first is a bit clock. It is the master clock divided by two or by four. The second is a frame (word-select) clock. It is the bit clock divided by 32, 64 or 128. Both outputs are registered square waves with a 50% duty cycle. The frame clock only changes at the same master-clock edge where the bit clock falls.

A single enable starts and stops both clocks together. While the enable is low, both clocks sit low and every counter is cleared. The bit-clock ratio and the frame ratio can be changed while the clocks run. The divider keeps the old setting until the next bit-clock falling edge. At that edge it adopts the new setting and starts a fresh frame with the low (left-channel) half.

Top module: `i2s_clkgen`

## Requirements
- R1: While `enable` is low, `bit_clk` and `frame_clk` are low at every sample, and changes on `bit_div4` or `frame_sel` have no visible effect on them.
- R2: With `bit_div4` = 0 the bit clock has a period of 2 master clocks: high 1, low 1.
- R3: With `bit_div4` = 1 the bit clock has a period of 4 master clocks: high 2, low 2. It is never high for more than two master clocks in a row.
- R4: `frame_sel` = 2'b00 gives a frame period of 32 bit-clock periods: 16 low, then 16 high.
- R5: `frame_sel` = 2'b01 gives a frame period of 64 bit-clock periods: 32 low, then 32 high.
- R6: `frame_sel` = 2'b10 gives a frame period of 128 bit-clock periods: 64 low, then 64 high.
- R7: `frame_sel` = 2'b11 is not a legal ratio. It holds `frame_clk` low while the bit clock keeps running.
- R8: `frame_clk` changes only at a master-clock edge where `bit_clk` falls, or when the enable is dropped.
- R9: After `enable` is first seen high, `bit_clk` rises after 1 master clock (divide by 2) or after 2 master clocks (divide by 4). `frame_clk` starts in its low half, and it first rises at the bit-clock falling edge that ends that half.
- R10: A change of `bit_div4` or `frame_sel` while enabled takes effect at the next bit-clock falling edge. At that edge `frame_clk` is forced low and both counters restart from zero, so the timing afterwards is the same as a fresh enable under the new setting.
- R11: While `rst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mst_clk | input | 1 | Audio master clock; every register runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs both derived clocks when high |
| bit_div4 | input | 1 | Bit-clock ratio: 0 divides by 2, 1 divides by 4 |
| frame_sel | input | 2 | Frame ratio: 00 = 32, 01 = 64, 10 = 128, 11 = frame clock held low |
| bit_clk | output | 1 | Derived bit clock |
| frame_clk | output | 1 | Derived frame clock, low half first |

## Verification
The bench uses the default parameters: a bit-clock half period of one or two master clocks and a shortest frame half of 16 bit clocks. With these values all six ratio combinations and the held-low code run for two full frames each, which takes only a few thousand cycles. It also includes a mid-frame switch from divide-by-2, ratio 32 to divide-by-4, ratio 64. In that test the restart edge is predicted from the old waveform and checked sample by sample.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;

    // Frame ratio codes; the code value is the left-shift applied to the base half period
    typedef enum logic [1:0] {
        FR_DIV32  = 2'b00,
        FR_DIV64  = 2'b01,
        FR_DIV128 = 2'b10,
        FR_HOLD   = 2'b11
    } frame_sel_e;

    typedef struct packed {
        logic       slow;
        frame_sel_e frame;
    } clk_cfg_t;

endpackage

// File: rtl/i2s_bitclk_div.sv
module i2s_bitclk_div #(
    parameter int HALF_FAST = 1,
    parameter int HALF_SLOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic slow,
    output logic bit_clk,
    output logic fall_evt
);

    localparam int HALF_MAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
    localparam int CW       = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          level;
    } bit_st_t;

    bit_st_t       s_d, s_q;
    logic [CW-1:0] last;

    always_comb begin
        last     = slow ? CW'(HALF_SLOW - 1) : CW'(HALF_FAST - 1);
        s_d      = s_q;
        fall_evt = 1'b0;
        if (!en) begin
            s_d = '0;
        end else if (s_q.cnt == last) begin
            s_d.cnt   = '0;
            s_d.level = ~s_q.level;
            fall_evt  = s_q.level;
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit_clk = s_q.level;

endmodule

// File: rtl/i2s_cfg_hold.sv
module i2s_cfg_hold
    import i2s_clkgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     fall_evt,
    input  clk_cfg_t cfg_in,
    output clk_cfg_t cfg,
    output logic     restart
);

    clk_cfg_t cfg_d, cfg_q;

    always_comb begin
        // A new setting is adopted only on a bit-clock falling edge while running
        restart = en && fall_evt && (cfg_in != cfg_q);
        cfg_d   = (!en || restart) ? cfg_in : cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/i2s_frame_div.sv
module i2s_frame_div
    import i2s_clkgen_pkg::*;
#(
    parameter int BASE_HALF = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       fall_evt,
    input  logic       restart,
    input  frame_sel_e sel,
    output logic       frame_clk
);

    localparam int HALF_MAX = BASE_HALF * 4;
    localparam int CW       = $clog2(HALF_MAX);
    localparam int LW       = CW + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          level;
    } frm_st_t;

    frm_st_t       s_d, s_q;
    logic [LW-1:0] lim;

    always_comb begin
        lim = LW'(BASE_HALF) << sel;
        s_d = s_q;
        if (!en || restart || sel == FR_HOLD) begin
            s_d = '0;
        end else if (fall_evt) begin
            if ({1'b0, s_q.cnt} == lim - LW'(1)) begin
                s_d.cnt   = '0;
                s_d.level = ~s_q.level;
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign frame_clk = s_q.level;

endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
    import i2s_clkgen_pkg::*;
#(
    parameter int BIT_HALF_FAST   = 1,
    parameter int BIT_HALF_SLOW   = 2,
    parameter int FRAME_BASE_HALF = 16
) (
    input  logic       mst_clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       bit_div4,
    input  logic [1:0] frame_sel,
    output logic       bit_clk,
    output logic       frame_clk
);

    clk_cfg_t cfg_in;
    clk_cfg_t cfg_act;
    logic     fall_evt;
    logic     restart;

    always_comb begin
        cfg_in.slow  = bit_div4;
        cfg_in.frame = frame_sel_e'(frame_sel);
    end

    i2s_cfg_hold u_cfg (
        .clk      (mst_clk),
        .rst_n    (rst_n),
        .en       (enable),
        .fall_evt (fall_evt),
        .cfg_in   (cfg_in),
        .cfg      (cfg_act),
        .restart  (restart)
    );

    i2s_bitclk_div #(
        .HALF_FAST (BIT_HALF_FAST),
        .HALF_SLOW (BIT_HALF_SLOW)
    ) u_bit (
        .clk      (mst_clk),
        .rst_n    (rst_n),
        .en       (enable),
        .slow     (cfg_act.slow),
        .bit_clk  (bit_clk),
        .fall_evt (fall_evt)
    );

    i2s_frame_div #(
        .BASE_HALF (FRAME_BASE_HALF)
    ) u_frame (
        .clk       (mst_clk),
        .rst_n     (rst_n),
        .en        (enable),
        .fall_evt  (fall_evt),
        .restart   (restart),
        .sel       (cfg_act.frame),
        .frame_clk (frame_clk)
    );

endmodule

// File: rtl/i2s_clkgen_chk.sv
module i2s_clkgen_chk (
    input logic mst_clk,
    input logic rst_n,
    input logic enable,
    input logic bit_clk,
    input logic frame_clk
);

    AST_OFF_LOW: assert property (@(posedge mst_clk) disable iff (!rst_n)
        !enable |=> (!bit_clk && !frame_clk)); // R1

    AST_BIT_NEEDS_EN: assert property (@(posedge mst_clk) disable iff (!rst_n)
        $rose(bit_clk) |-> $past(enable)); // R1

    AST_BIT_HIGH_MAX: assert property (@(posedge mst_clk) disable iff (!rst_n)
        (bit_clk && $past(bit_clk)) |=> !bit_clk); // R3

    AST_FRAME_ON_FALL: assert property (@(posedge mst_clk) disable iff (!rst_n)
        !$stable(frame_clk) |-> ($fell(bit_clk) || !$past(enable))); // R8

    AST_FRAME_START_LOW: assert property (@(posedge mst_clk) disable iff (!rst_n)
        $rose(enable) |=> !frame_clk); // R9

endmodule

bind i2s_clkgen i2s_clkgen_chk u_chk (
    .mst_clk   (mst_clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .bit_clk   (bit_clk),
    .frame_clk (frame_clk)
);

// File: tb/tb_i2s_clkgen.sv
`timescale 1ns/1ps
module tb_i2s_clkgen;

    logic       mst_clk = 1'b0;
    logic       rst_n;
    logic       enable;
    logic       bit_div4;
    logic [1:0] frame_sel;
    logic       bit_clk;
    logic       frame_clk;

    int checks = 0;
    int errors = 0;

    always #2.5 mst_clk = ~mst_clk;

    i2s_clkgen dut (
        .mst_clk   (mst_clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .bit_div4  (bit_div4),
        .frame_sel (frame_sel),
        .bit_clk   (bit_clk),
        .frame_clk (frame_clk)
    );

    // Expected {bit, frame} at sample i after a fresh start (i = 0 is the first sample after enable is taken)
    function automatic logic [1:0] model(input int i, input bit slow, input int sel);
        int h, t, f;
        logic b, l;
        if (i < 0) return 2'b00;
        h = slow ? 2 : 1;
        t = (i + 1) / h;
        b = logic'(t % 2);
        f = t / 2;
        l = (sel == 3) ? 1'b0 : logic'((f / (16 << sel)) % 2);
        return {b, l};
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; enable = 1'b1; bit_div4 = 1'b0; frame_sel = 2'b00;
        repeat (4) @(negedge mst_clk);
        chk(bit_clk == 1'b0 && frame_clk == 1'b0, "R11", "outputs in reset",
            {bit_clk, frame_clk}, 0);
        enable = 1'b0;
        @(negedge mst_clk);
        rst_n = 1'b1;
        repeat (2) @(negedge mst_clk);
    endtask

    // Runs one ratio pair from a fresh enable; checks R2/R3 on the bit clock,
    // R4..R7 on the frame clock, and R8 R9 through the exact per-sample model
    task automatic t_mode(input bit slow, input int sel);
        int    n, bad_b, bad_l;
        logic [1:0] e, ab, eb, al, el;
        string rb, rl;
        rb = slow ? "R3 R9" : "R2 R9";
        case (sel)
            0: rl = "R4 R8 R9";
            1: rl = "R5 R8 R9";
            2: rl = "R6 R8 R9";
            default: rl = "R7";
        endcase
        n = (sel == 3) ? 300 : 2 * ((32 << sel) * 2 * (slow ? 2 : 1)) + 8;
        enable = 1'b0; bit_div4 = slow; frame_sel = 2'(sel);
        repeat (3) @(negedge mst_clk);
        enable = 1'b1;
        bad_b = -1; bad_l = -1;
        ab = '0; eb = '0; al = '0; el = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge mst_clk);
            e = model(i, slow, sel);
            if (bad_b < 0 && bit_clk !== e[1]) begin bad_b = i; ab = {1'b0, bit_clk}; eb = {1'b0, e[1]}; end
            if (bad_l < 0 && frame_clk !== e[0]) begin bad_l = i; al = {1'b0, frame_clk}; el = {1'b0, e[0]}; end
        end
        chk(bad_b < 0, rb, $sformatf("bit clock slow=%0d sel=%0d sample %0d", slow, sel, bad_b), ab, eb);
        chk(bad_l < 0, rl, $sformatf("frame clock slow=%0d sel=%0d sample %0d", slow, sel, bad_l), al, el);
        enable = 1'b0;
        @(negedge mst_clk);
    endtask

    // R1: held low while disabled, whatever the settings do
    task automatic t_disabled();
        int bad;
        enable = 1'b1; bit_div4 = 1'b0; frame_sel = 2'b00;
        repeat (50) @(negedge mst_clk);
        enable = 1'b0;
        bad = -1;
        for (int i = 0; i < 60; i++) begin
            bit_div4  = logic'(i % 2);
            frame_sel = 2'(i % 4);
            @(negedge mst_clk);
            if (bad < 0 && (bit_clk !== 1'b0 || frame_clk !== 1'b0)) bad = i;
        end
        chk(bad < 0, "R1", $sformatf("outputs while disabled, sample %0d", bad),
            {bit_clk, frame_clk}, 0);
    endtask

    // R10: switch from divide-2/ratio-32 to divide-4/ratio-64 mid frame
    task automatic t_change();
        int c, s, bad, act, exp;
        logic [1:0] e, got;
        enable = 1'b0; bit_div4 = 1'b0; frame_sel = 2'b00;
        repeat (3) @(negedge mst_clk);
        enable = 1'b1;
        c = 40;
        bad = -1; act = 0; exp = 0;
        for (int i = 0; i <= c; i++) begin
            @(negedge mst_clk);
            e = model(i, 1'b0, 0);
            got = {bit_clk, frame_clk};
            if (bad < 0 && got !== e) begin bad = i; act = got; exp = e; end
        end
        bit_div4 = 1'b1; frame_sel = 2'b01;
        s = c + 1;
        while (!(model(s, 1'b0, 0) == 2'b00 || model(s, 1'b0, 0) == 2'b01) ||
               model(s - 1, 1'b0, 0) < 2'b10)
            s++;
        for (int i = c + 1; i < c + 700; i++) begin
            @(negedge mst_clk);
            e = (i < s) ? model(i, 1'b0, 0) : model(i - s - 1, 1'b1, 1);
            got = {bit_clk, frame_clk};
            if (bad < 0 && got !== e) begin bad = i; act = got; exp = e; end
        end
        chk(bad < 0, "R10", $sformatf("{bit,frame} across setting change, sample %0d", bad), act, exp);
        enable = 1'b0;
        @(negedge mst_clk);
    endtask

    initial begin
        t_reset();
        t_mode(1'b0, 0);
        t_mode(1'b0, 1);
        t_mode(1'b0, 2);
        t_mode(1'b1, 0);
        t_mode(1'b1, 1);
        t_mode(1'b1, 2);
        t_mode(1'b0, 3);
        t_mode(1'b1, 3);
        t_disabled();
        t_change();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL R11: watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule